// File: doc/BRIEF.md
# Priority-Based Pending Interrupt Selector

This block picks the one interrupt that a single target context should take next. Each source has a pending bit, a claimed bit and a 4-bit priority. A source is a candidate when it is pending, is not claimed, has a nonzero ID and lies below a run-time source limit. The highest priority among the candidates wins. When priorities are equal, the lower ID wins. A candidate with priority 0 can still win if no other candidate exists. ID 0 means no interrupt.

The selection is made by a balanced binary tree of compare nodes over a leaf stage that qualifies each source. The winning ID, a valid flag and the interrupt request line toward the hart are registered. The outputs therefore show the inputs that were present at the previous rising clock edge, one cycle of latency. The register interface, claim/complete bookkeeping and source capture sit in neighbouring blocks.

Top module: `prio_pick_sel`

## Requirements
- R1: ID 0 never names a source. When no candidate exists, `win_id_o` is 0 and `win_valid_o` is low. When a candidate exists, `win_id_o` is nonzero.
- R2: Among candidates of equal priority, the one with the smaller ID is selected.
- R3: A source takes part only when its bit in `pend_i` is 1 and its bit in `claim_i` is 0. A claimed source is never selected, even if it is pending and has the top priority.
- R4: A source whose ID is greater than or equal to `src_limit_i` is never selected. A limit of 0 or 1 means no source can be selected.
- R5: The candidate with the strictly highest priority is selected. Source k's priority is field `prio_i[4k+3:4k]`. A candidate with priority 0 is selected if it is the only candidate.
- R6: `irq_o` and `win_valid_o` are both 1 exactly when `win_id_o` is nonzero.
- R7: The outputs reflect the inputs sampled at the previous rising edge of `clk_i`, a latency of one cycle. While `rst_ni` is low, all outputs are 0.
- R8: Bit 0 of `pend_i` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | NUM_SRC | Pending bit of each source; bit k belongs to ID k |
| claim_i | input | NUM_SRC | Claimed bit of each source |
| prio_i | input | 4*NUM_SRC | Priority of each source, 4 bits per source, source k at bits 4k+3:4k |
| src_limit_i | input | $clog2(NUM_SRC)+1 | Number of configured IDs; IDs at or above this value are excluded |
| win_id_o | output | $clog2(NUM_SRC) | Selected source ID, 0 when none |
| win_valid_o | output | 1 | A winner exists |
| irq_o | output | 1 | Interrupt request toward the hart |

## Verification
Three functions can act on the same source in the same cycle: the claim mask, the source limit and the priority comparison. A typical case is a source that has the top priority and is also claimed or beyond the limit, while a lower-priority source is still eligible. The bench builds such cases on purpose. It also draws random vectors with dense claimed sets, random limits and priorities squeezed into one or two values, so that ties and masking happen together. Each registered result is compared one cycle later with a reference scan written in the bench. That scan walks the IDs upward and replaces the current best only on a strictly greater priority.

// File: rtl/prio_pick_pkg.sv
package prio_pick_pkg;
  localparam int unsigned PRIO_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/prio_pick_qualify.sv
module prio_pick_qualify #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] claim_i,
  input  logic [ID_W:0]      src_limit_i,
  output logic [NUM_SRC-1:0] cand_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    if (k == 0) begin : g_none
      // ID 0 is reserved; its pending bit is dropped
      assign cand_o[k] = 1'b0;
    end else begin : g_real
      assign cand_o[k] = pend_i[k] & ~claim_i[k] & ((ID_W+1)'(k) < src_limit_i);
    end
  end
endmodule

// File: rtl/prio_pick_merge.sv
module prio_pick_merge
  import prio_pick_pkg::*;
#(
  parameter int unsigned ID_W = 5
) (
  input  logic            lo_v_i,
  input  prio_t           lo_p_i,
  input  logic [ID_W-1:0] lo_id_i,
  input  logic            hi_v_i,
  input  prio_t           hi_p_i,
  input  logic [ID_W-1:0] hi_id_i,
  output logic            v_o,
  output prio_t           p_o,
  output logic [ID_W-1:0] id_o
);
  logic take_hi;
  // upper half holds larger IDs: it wins only on strictly higher priority
  assign take_hi = hi_v_i & (~lo_v_i | (hi_p_i > lo_p_i));
  assign v_o  = lo_v_i | hi_v_i;
  assign p_o  = take_hi ? hi_p_i  : lo_p_i;
  assign id_o = take_hi ? hi_id_i : lo_id_i;
endmodule

// File: rtl/prio_pick_tree.sv
module prio_pick_tree
  import prio_pick_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned ID_W   = $clog2(NUM_SRC),
  localparam int unsigned LEAVES = 1 << ID_W
) (
  input  logic [NUM_SRC-1:0]        cand_i,
  input  logic [PRIO_W*NUM_SRC-1:0] prio_i,
  output logic                      v_o,
  output logic [ID_W-1:0]           id_o
);
  logic            node_v  [1:2*LEAVES-1];
  prio_t           node_p  [1:2*LEAVES-1];
  logic [ID_W-1:0] node_id [1:2*LEAVES-1];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NUM_SRC) begin : g_used
      assign node_v[LEAVES+k]  = cand_i[k];
      assign node_p[LEAVES+k]  = prio_i[PRIO_W*k +: PRIO_W];
    end else begin : g_pad
      assign node_v[LEAVES+k]  = 1'b0;
      assign node_p[LEAVES+k]  = '0;
    end
    assign node_id[LEAVES+k] = ID_W'(k);
  end

  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    prio_pick_merge #(.ID_W(ID_W)) i_merge (
      .lo_v_i (node_v[2*n]),
      .lo_p_i (node_p[2*n]),
      .lo_id_i(node_id[2*n]),
      .hi_v_i (node_v[2*n+1]),
      .hi_p_i (node_p[2*n+1]),
      .hi_id_i(node_id[2*n+1]),
      .v_o    (node_v[n]),
      .p_o    (node_p[n]),
      .id_o   (node_id[n])
    );
  end

  assign v_o  = node_v[1];
  assign id_o = node_v[1] ? node_id[1] : '0;
endmodule

// File: rtl/prio_pick_sel.sv
module prio_pick_sel
  import prio_pick_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        claim_i,
  input  logic [PRIO_W*NUM_SRC-1:0] prio_i,
  input  logic [ID_W:0]             src_limit_i,
  output logic [ID_W-1:0]           win_id_o,
  output logic                      win_valid_o,
  output logic                      irq_o
);
  logic [NUM_SRC-1:0] cand;
  logic               tree_v;
  logic [ID_W-1:0]    tree_id;

  prio_pick_qualify #(.NUM_SRC(NUM_SRC)) i_qualify (
    .pend_i     (pend_i),
    .claim_i    (claim_i),
    .src_limit_i(src_limit_i),
    .cand_o     (cand)
  );

  prio_pick_tree #(.NUM_SRC(NUM_SRC)) i_tree (
    .cand_i(cand),
    .prio_i(prio_i),
    .v_o   (tree_v),
    .id_o  (tree_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_id_o    <= '0;
      win_valid_o <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      win_id_o    <= tree_id;
      win_valid_o <= tree_v;
      irq_o       <= tree_v;
    end
  end
endmodule

// File: rtl/prio_pick_sel_chk.sv
module prio_pick_sel_chk
  import prio_pick_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_SRC-1:0]        pend_i,
  input logic [NUM_SRC-1:0]        claim_i,
  input logic [PRIO_W*NUM_SRC-1:0] prio_i,
  input logic [ID_W:0]             src_limit_i,
  input logic [ID_W-1:0]           win_id_o,
  input logic                      win_valid_o,
  input logic                      irq_o
);
  logic [NUM_SRC-1:0]        pend_q, claim_q;
  logic [PRIO_W*NUM_SRC-1:0] prio_q;
  logic [ID_W:0]             lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      claim_q <= '0;
      prio_q  <= '0;
      lim_q   <= '0;
    end else begin
      pend_q  <= pend_i;
      claim_q <= claim_i;
      prio_q  <= prio_i;
      lim_q   <= src_limit_i;
    end
  end

  logic  any_elig, beaten;
  prio_t win_p;
  assign win_p = prio_q[PRIO_W*win_id_o +: PRIO_W];

  always_comb begin
    any_elig = 1'b0;
    beaten   = 1'b0;
    for (int k = 1; k < NUM_SRC; k++) begin
      if (pend_q[k] && !claim_q[k] && (k < int'(lim_q))) begin
        any_elig = 1'b1;
        if (k != int'(win_id_o)) begin
          if (prio_q[PRIO_W*k +: PRIO_W] > win_p) beaten = 1'b1;
          if (prio_q[PRIO_W*k +: PRIO_W] == win_p && k < int'(win_id_o)) beaten = 1'b1;
        end
      end
    end
  end

  AST_NONE_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_valid_o |-> win_id_o == '0);                                       // R1
  AST_VALID_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> win_id_o != '0);                                        // R1
  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (win_id_o != '0));                                             // R6
  AST_WIN_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (pend_q[win_id_o] && !claim_q[win_id_o]));              // R3
  AST_WIN_IN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> ({1'b0, win_id_o} < lim_q));                            // R4
  AST_NOT_BEATEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> !beaten);                                               // R5
  AST_NO_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o == any_elig);                                               // R7
endmodule

bind prio_pick_sel prio_pick_sel_chk #(.NUM_SRC(NUM_SRC)) i_prio_pick_sel_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pend_i     (pend_i),
  .claim_i    (claim_i),
  .prio_i     (prio_i),
  .src_limit_i(src_limit_i),
  .win_id_o   (win_id_o),
  .win_valid_o(win_valid_o),
  .irq_o      (irq_o)
);

// File: tb/test_prio_pick_sel.sv
`timescale 1ns/1ps
module test_prio_pick_sel;
  localparam int N    = 32;
  localparam int ID_W = $clog2(N);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N-1:0]      pend_i = '0;
  logic [N-1:0]      claim_i = '0;
  logic [4*N-1:0]    prio_i = '0;
  logic [ID_W:0]     src_limit_i = '0;
  logic [ID_W-1:0]   win_id_o;
  logic              win_valid_o;
  logic              irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  prio_pick_sel #(.NUM_SRC(N)) i_prio_pick_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend_i), .claim_i(claim_i),
    .prio_i(prio_i), .src_limit_i(src_limit_i), .win_id_o(win_id_o),
    .win_valid_o(win_valid_o), .irq_o(irq_o));

  function automatic int ref_pick(logic [N-1:0] p, logic [N-1:0] c,
                                  logic [4*N-1:0] pr, int lim);
    int best = 0;
    int bp = 0;
    for (int i = 1; i < N; i++) begin
      if (i < lim && p[i] && !c[i]) begin
        if (best == 0 || int'(pr[4*i +: 4]) > bp) begin
          best = i;
          bp = int'(pr[4*i +: 4]);
        end
      end
    end
    return best;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // apply at negedge, sample just after the next rising edge
  task automatic apply_check(string req, logic [N-1:0] p, logic [N-1:0] c,
                             logic [4*N-1:0] pr, int lim);
    int e;
    @(negedge clk_i);
    pend_i = p; claim_i = c; prio_i = pr; src_limit_i = (ID_W+1)'(lim);
    e = ref_pick(p, c, pr, lim);
    @(posedge clk_i); #1;
    check(req, int'(win_id_o), e);
    check("R6", int'(irq_o), int'(e != 0));
    check("R6", int'(win_valid_o), int'(e != 0));
  endtask

  function automatic logic [4*N-1:0] all_prio(int v);
    logic [4*N-1:0] r;
    for (int i = 0; i < N; i++) r[4*i +: 4] = 4'(v);
    return r;
  endfunction

  initial begin
    #(5.0 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [4*N-1:0] pr;
    void'($urandom(32'd7719));
    pend_i = '1; src_limit_i = (ID_W+1)'(N); prio_i = all_prio(5);
    repeat (3) @(posedge clk_i);
    #1;
    check("R7 reset id", int'(win_id_o), 0);
    check("R7 reset irq", int'(irq_o), 0);
    check("R7 reset valid", int'(win_valid_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    apply_check("R1 empty", '0, '0, all_prio(7), N);
    apply_check("R8 only bit0", 32'h1, '0, all_prio(7), N);
    apply_check("R2 all equal", '1, '0, all_prio(3), N);
    check("R2 lowest id", int'(win_id_o), 1);
    pr = all_prio(2); pr[4*9 +: 4] = 4'd15; pr[4*20 +: 4] = 4'd15;
    apply_check("R5 max wins", '1, '0, pr, N);
    check("R5 id9", int'(win_id_o), 9);
    apply_check("R3 top claimed", '1, 32'h0000_0200, pr, N);
    check("R3 id20", int'(win_id_o), 20);
    apply_check("R4 limit clip", '1, 32'h0000_0200, pr, 20);
    check("R4 id1", int'(win_id_o), 1);
    apply_check("R4 limit one", '1, '0, pr, 1);
    apply_check("R5 sole prio0", 32'h0001_0000, '0, all_prio(0), N);
    check("R5 id16", int'(win_id_o), 16);
    apply_check("R3 all claimed", '1, '1, pr, N);
    apply_check("R8 bit0 top", 32'h0000_0011, '0, all_prio(9), N);
    check("R8 id4", int'(win_id_o), 4);

    // R7: one-cycle latency, output follows the new input at the next edge
    @(negedge clk_i);
    pend_i = 32'h0000_0100; claim_i = '0; prio_i = all_prio(1); src_limit_i = (ID_W+1)'(N);
    #1 check("R7 held before edge", int'(win_id_o), 4);
    @(posedge clk_i); #1;
    check("R7 updated", int'(win_id_o), 8);

    for (int t = 0; t < 400; t++) begin
      logic [N-1:0] p, c;
      logic [4*N-1:0] r;
      int lim;
      p = $urandom();
      if (t % 4 == 1) p = p & $urandom();
      c = $urandom() & $urandom();
      if (t % 5 == 2) c = $urandom();
      for (int i = 0; i < N; i++) r[4*i +: 4] = 4'($urandom());
      if (t % 3 == 0) r = r & all_prio(1);
      lim = (t % 2 == 0) ? N : int'($urandom_range(0, N));
      apply_check("R5 random", p, c, r, lim);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule